// File: doc/BRIEF.md
# Configurable Frame Signal Generator

This block drives the FRAME line of a parallel bus. It observes three event inputs: a one-cycle bus clock enable, a level that is high while a transaction is in progress, and a one-cycle pulse that marks the start of each transaction. From these it produces one FRAME output. Two configuration inputs shape that output: a frame length field and a mode bit.

In pulse mode, the block counts bus clocks during a transaction. FRAME is high for the first bus clock of each group of length plus one, and low for the rest of the group. A length of zero turns FRAME into a plain transaction-valid level.

In half-duty mode, the block counts transaction-start pulses instead of bus clocks. FRAME holds its level for length plus one transactions and then inverts. A length of zero therefore inverts FRAME on every transaction.

Any change to the configuration restarts the generator from its reset state.

Top module: `frame_gen`

## Requirements
- R1: After reset, `frame` is low.
- R2: In pulse mode (`cfg_half`=0) with `cfg_len`=0, `frame` equals the value that `xact_active` had in the previous clock cycle.
- R3: In pulse mode with `cfg_len`=N>0, each cycle with `bus_ce`=1 and `xact_active`=1 is a counted bus clock. `frame` becomes 1 after the first counted bus clock of each group of N+1 and 0 after the other N. Between counted bus clocks inside a transaction, `frame` holds its level.
- R4: In pulse mode with N>0, a cycle with `xact_active`=0 drives `frame` low in the next cycle. The bus clock position is kept, and counting resumes from it when the transaction becomes active again.
- R5: In half-duty mode (`cfg_half`=1) with `cfg_len`=N, each `xact_start` pulse advances a transaction counter that wraps after N+1 pulses. `frame` inverts on the pulse that finds the counter at zero, so the first transaction after a restart raises `frame`.
- R6: In half-duty mode, `cfg_len`=0 inverts `frame` on every `xact_start` pulse, and `cfg_len`=15 inverts it on every sixteenth pulse.
- R7: In a cycle where {`cfg_half`,`cfg_len`} differs from its value in the previous cycle (or from zero, the first time after reset), `frame` and both counters clear. The events of that cycle are ignored.
- R8: In half-duty mode, `bus_ce` and `xact_active` have no effect on `frame`.
- R9: In pulse mode, `xact_start` has no effect on `frame`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 4 | Frame length field N; period is N+1 |
| cfg_half | input | 1 | 0 = pulse mode, 1 = half-duty mode |
| bus_ce | input | 1 | One-cycle enable marking a bus clock |
| xact_active | input | 1 | High while a transaction is in progress |
| xact_start | input | 1 | One-cycle pulse at the start of a transaction |
| frame | output | 1 | Frame output, valid one cycle after the events it reflects |

## Verification
A configuration change can fall in the same cycle as a counted event, either a transaction-start pulse in half-duty mode or a counted bus clock in pulse mode. The bench provokes this by writing a new length or mode in the very cycle that carries the event. It judges the outcome in two steps. First, `frame` must read low in the following cycle. Second, the next event must behave as the first one after a restart, which means the swallowed event was not counted.

// File: rtl/frame_gen_pkg.sv
package frame_gen_pkg;
   typedef enum logic {
      FRM_MODE_PULSE = 1'b0,
      FRM_MODE_HALF  = 1'b1
   } frm_mode_e;

   function automatic int frm_period(input int len);
      return len + 1;
   endfunction
endpackage

// File: rtl/frame_cfg_track.sv
module frame_cfg_track #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_half,
   output logic             cfg_chg
);
   localparam int CFG_W = LEN_W + 1;

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;

   assign cfg_now = {cfg_half, cfg_len};
   assign cfg_chg = (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg_now;
      end
   end
endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [LEN_W-1:0] len,
   input  logic             bus_ce,
   input  logic             xact_active,
   output logic             pulse_q
);
   logic [LEN_W-1:0] clk_cnt;
   logic             len_zero;
   logic             at_wrap;

   assign len_zero = (len == '0);
   assign at_wrap  = (clk_cnt == len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_cnt <= '0;
         pulse_q <= 1'b0;
      end else if (clr) begin
         clk_cnt <= '0;
         pulse_q <= 1'b0;
      end else if (en) begin
         if (len_zero) begin
            clk_cnt <= '0;
            pulse_q <= xact_active;
         end else if (!xact_active) begin
            pulse_q <= 1'b0;
         end else if (bus_ce) begin
            pulse_q <= (clk_cnt == '0);
            clk_cnt <= at_wrap ? '0 : clk_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/frame_half_gen.sv
module frame_half_gen #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [LEN_W-1:0] len,
   input  logic             xact_start,
   output logic             half_q
);
   logic [LEN_W-1:0] tr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tr_cnt <= '0;
         half_q <= 1'b0;
      end else if (clr) begin
         tr_cnt <= '0;
         half_q <= 1'b0;
      end else if (en && xact_start) begin
         if (tr_cnt == '0) begin
            half_q <= ~half_q;
         end
         tr_cnt <= (tr_cnt == len) ? '0 : tr_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/frame_gen.sv
module frame_gen
   import frame_gen_pkg::*;
#(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_half,
   input  logic             bus_ce,
   input  logic             xact_active,
   input  logic             xact_start,
   output logic             frame
);
   localparam int MAX_PERIOD = 1 << LEN_W;

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("frame_gen: LEN_W must be within 1..16");
      end
      if (frm_period(MAX_PERIOD - 1) != MAX_PERIOD) begin : g_bad_period
         $error("frame_gen: period derivation inconsistent");
      end
   endgenerate

   frm_mode_e mode;
   logic      cfg_chg;
   logic      pulse_q;
   logic      half_q;

   assign mode = frm_mode_e'(cfg_half);

   frame_cfg_track #(.LEN_W(LEN_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_len  (cfg_len),
      .cfg_half (cfg_half),
      .cfg_chg  (cfg_chg)
   );

   frame_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (cfg_chg),
      .en          (mode == FRM_MODE_PULSE),
      .len         (cfg_len),
      .bus_ce      (bus_ce),
      .xact_active (xact_active),
      .pulse_q     (pulse_q)
   );

   frame_half_gen #(.LEN_W(LEN_W)) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cfg_chg),
      .en         (mode == FRM_MODE_HALF),
      .len        (cfg_len),
      .xact_start (xact_start),
      .half_q     (half_q)
   );

   assign frame = (mode == FRM_MODE_HALF) ? half_q : pulse_q;
endmodule

// File: rtl/frame_gen_chk.sv
module frame_gen_chk #(
   parameter int LEN_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LEN_W-1:0] cfg_len,
   input logic             cfg_half,
   input logic             bus_ce,
   input logic             xact_active,
   input logic             xact_start,
   input logic             cfg_chg,
   input logic             frame
);
   AST_CFG_CLEARS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> !frame); // R7

   AST_ZERO_FOLLOWS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_half && cfg_len == '0 && !cfg_chg) |=> (frame == $past(xact_active))); // R2

   AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_half && cfg_len != '0 && xact_active && !bus_ce && !cfg_chg) |=> $stable(frame)); // R3

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_half && cfg_len != '0 && !xact_active) |=> !frame); // R4

   AST_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_half && !xact_start && !cfg_chg) |=> $stable(frame)); // R8

   AST_HALF_ZERO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_half && cfg_len == '0 && xact_start && !cfg_chg) |=> (frame != $past(frame))); // R6
endmodule

bind frame_gen frame_gen_chk #(.LEN_W(LEN_W)) u_frame_gen_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_len     (cfg_len),
   .cfg_half    (cfg_half),
   .bus_ce      (bus_ce),
   .xact_active (xact_active),
   .xact_start  (xact_start),
   .cfg_chg     (cfg_chg),
   .frame       (frame)
);

// File: tb/test_frame_gen.sv
module test_frame_gen;
   localparam int CLK_P = 10;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cfg_len = '0;
   logic       cfg_half = 1'b0;
   logic       bus_ce = 1'b0;
   logic       xact_active = 1'b0;
   logic       xact_start = 1'b0;
   logic       frame;

   int n_cmp = 0;
   int n_bad = 0;
   item_t sb[$];

   logic [3:0] nx_len = '0;
   logic       nx_half = 1'b0;

   logic [4:0] m_cfg = '0;
   logic [3:0] m_pc = '0;
   logic       m_pf = 1'b0;
   logic [3:0] m_tc = '0;
   logic       m_tf = 1'b0;

   frame_gen i_frame_gen (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_half(cfg_half),
      .bus_ce(bus_ce), .xact_active(xact_active), .xact_start(xact_start),
      .frame(frame)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic step(input logic ce, input logic act, input logic st, input string tag);
      item_t it;
      @(negedge clk);
      cfg_len = nx_len;
      cfg_half = nx_half;
      bus_ce = ce;
      xact_active = act;
      xact_start = st;
      if ({nx_half, nx_len} != m_cfg) begin
         m_pc = '0; m_pf = 1'b0; m_tc = '0; m_tf = 1'b0;
      end else if (!nx_half) begin
         if (nx_len == 0) m_pf = act;
         else if (!act) m_pf = 1'b0;
         else if (ce) begin
            m_pf = (m_pc == 0);
            m_pc = (m_pc == nx_len) ? 4'd0 : m_pc + 4'd1;
         end
      end else if (st) begin
         if (m_tc == 0) m_tf = ~m_tf;
         m_tc = (m_tc == nx_len) ? 4'd0 : m_tc + 4'd1;
      end
      m_cfg = {nx_half, nx_len};
      it.exp = nx_half ? m_tf : m_pf;
      it.tag = tag;
      #(CLK_P/4);
      sb.push_back(it);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (frame !== it.exp) begin
               n_bad++;
               $display("FAIL %s: frame=%b expected=%b at %0t", it.tag, frame, it.exp, $time);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P*3);
      n_cmp++;
      if (frame !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: frame=%b expected=0 in reset", frame);
      end
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, "R1");
      // R2: len 0 pulse mode follows active
      for (int i = 0; i < 20; i++) step(i[0], (i % 5) < 3, 0, "R2");
      // R3: len 2, bus clock every cycle
      nx_len = 4'd2;
      for (int i = 0; i < 14; i++) step(1, 1, 0, "R3");
      // R3: bus clock every third cycle, with holds between
      nx_len = 4'd3;
      for (int i = 0; i < 30; i++) step((i % 3) == 0, 1, 0, "R3");
      // R4: active drops then resumes
      for (int i = 0; i < 30; i++) step(i[0], (i % 7) != 3 && (i % 7) != 4, 0, "R4");
      // R9: starts in pulse mode are ignored
      for (int i = 0; i < 20; i++) step((i % 2) == 0, 1, 1, "R9");
      // R5: half mode len 1
      nx_half = 1'b1; nx_len = 4'd1;
      for (int i = 0; i < 24; i++) step(0, 1, (i % 3) == 0, "R5");
      // R6: len 0 toggles each start
      nx_len = 4'd0;
      for (int i = 0; i < 16; i++) step(0, 0, i[0], "R6");
      // R6: len 15, every sixteenth start
      nx_len = 4'd15;
      for (int i = 0; i < 80; i++) step(0, 0, 1, "R6");
      // R8: bus clock and active wiggle without starts
      nx_len = 4'd2;
      step(0, 0, 1, "R8");
      for (int i = 0; i < 20; i++) step(i[0], (i % 3) != 0, 0, "R8");
      // R7: config change in the same cycle as a start
      for (int i = 0; i < 6; i++) step(0, 1, 1, "R7");
      nx_len = 4'd1;
      step(0, 1, 1, "R7");
      for (int i = 0; i < 8; i++) step(0, 1, 1, "R7");
      // R7: mode change during a counted bus clock
      nx_half = 1'b0; nx_len = 4'd2;
      step(1, 1, 0, "R7");
      for (int i = 0; i < 8; i++) step(1, 1, 0, "R7");
      nx_len = 4'd4;
      step(1, 1, 0, "R7");
      for (int i = 0; i < 12; i++) step(1, 1, 0, "R7");
      step(0, 0, 0, "R4");
      step(0, 0, 0, "R4");
      #(CLK_P/2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule